// File: doc/BRIEF.md
# Omega Multistage Routing Network

An eight-port interconnect that carries request messages from processor ports to memory-module ports. It has three stages of four two-by-two switch elements, with perfect-shuffle wiring ahead of each stage. Each request carries a 3-bit destination module number, a word address, a read/write opcode and a 32-bit write operand. Stage k routes on bit (2-k) of the module number: a 0 takes the upper output and a 1 takes the lower one. Each switch then writes the number of the input line the message came in on (0 upper, 1 lower) into the bit it has just used. When a request reaches its memory port, the field has become the requesting processor's index. A mirrored return fabric in the same block reads that field from the least significant bit upward. It carries a reply back along the same switches to the processor and restores the memory number into the field as it goes.

The network can block. Two messages that want the same switch output in the same cycle cannot both pass. A round-robin pointer at every switch output picks the winner, and the loser sees its ready low and holds its message. A message crosses all three stages in the cycle it is offered. There is no buffering inside the network. The memory side always accepts what is delivered.

Top module: `omega_net`

## Requirements
- R1: An accepted request appears on the memory port whose index equals its 3-bit module field, in the same cycle it is accepted.
- R2: The path field delivered with a request equals the index of the requesting processor. Bit 2 holds the first stage's input line, bit 1 the second's and bit 0 the third's, so processor 011 sending to module 110 arrives with 011.
- R3: Address, opcode (req_write 1 = WRITE, 0 = READ) and write operand arrive unchanged with the request.
- R4: An accepted reply presented on memory port m with path field p appears on processor port p, with cpu_module equal to m and its data unchanged.
- R5: A request or reply is accepted in the cycle it is offered when no other message offered in that cycle, in the same direction, needs any switch output it needs. This includes any message offered alone.
- R6: Ready is raised only for an offered message. The number of delivered outputs equals the number of acceptances. No two messages accepted in the same cycle share a switch output.
- R7: When two messages contend for one switch output, exactly one is accepted. The other gets ready low and produces no output. A held message is delivered once the contention clears.
- R8: When the same two messages keep contending for a switch output, each accepted win passes priority to the other, so acceptances alternate.
- R9: During and after reset, with nothing offered, no memory or processor port shows valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 8 | Request offered, one bit per processor |
| req_ready | output | 8 | Request accepted this cycle |
| req_module | input | 24 | Destination module, 3 bits per processor |
| req_addr | input | 128 | Word address, 16 bits per processor |
| req_write | input | 8 | Opcode, 1 = WRITE, 0 = READ |
| req_wdata | input | 256 | Write operand, 32 bits per processor |
| mem_valid | output | 8 | Request delivered, one bit per memory port |
| mem_path | output | 24 | Rewritten path field, 3 bits per memory port |
| mem_addr | output | 128 | Delivered address |
| mem_write | output | 8 | Delivered opcode |
| mem_wdata | output | 256 | Delivered operand |
| rsp_valid | input | 8 | Reply offered, one bit per memory port |
| rsp_ready | output | 8 | Reply accepted this cycle |
| rsp_path | input | 24 | Return path field, 3 bits per memory port |
| rsp_data | input | 256 | Reply data, 32 bits per memory port |
| cpu_valid | output | 8 | Reply delivered, one bit per processor |
| cpu_module | output | 24 | Restored module number per processor |
| cpu_data | output | 256 | Delivered reply data |

## Verification
The hardest case to reach from the ports is contention inside the network rather than at a final port. Two requests bound for different modules can still collide at a first- or second-stage switch output. Whether they do depends on the shuffle wiring, not on the visible addresses. To find such cases, the stimulus keeps many processors and memory ports busy at random with held messages. A behavioural model computes the switch outputs each message needs and checks every cycle that messages with clear paths pass and that the accepted set never shares a link. Fixed pairs cover the sweep of all 64 single routes and the repeated contest for round-robin alternation.

// File: rtl/omega_fabric.sv
module omega_fabric #(
  parameter int N   = 8,
  parameter int PW  = 8,
  parameter bit REV = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            in_valid,
  input  logic [N*$clog2(N)-1:0]  in_tag,
  input  logic [N*PW-1:0]         in_pay,
  output logic [N-1:0]            in_ready,
  output logic [N-1:0]            out_valid,
  output logic [N*$clog2(N)-1:0]  out_tag,
  output logic [N*PW-1:0]         out_pay
);
  localparam int LG = $clog2(N);
  localparam int H  = N / 2;

  logic [N-1:0]    done;
  logic [N*LG-1:0] fin_org;

  for (genvar g = 0; g < LG; g++) begin : st
    localparam int S  = REV ? LG - 1 - g : g;
    localparam int BI = LG - 1 - S;

    logic [N-1:0]    pv, av, bv, nv;
    logic [N*LG-1:0] pt, at, bt, nt;
    logic [N*LG-1:0] po, ao, bo, no;
    logic [N*PW-1:0] pd, ad, bd, nd;

    if (g == 0) begin : from_ports
      assign pv = in_valid;
      assign pt = in_tag;
      assign pd = in_pay;
      for (genvar q = 0; q < N; q++) begin : org
        assign po[q*LG +: LG] = LG'(q);
      end
    end else begin : from_prev
      assign pv = st[g-1].nv;
      assign pt = st[g-1].nt;
      assign pd = st[g-1].nd;
      assign po = st[g-1].no;
    end

    for (genvar j = 0; j < N; j++) begin : perm
      localparam int SH = ((j << 1) | (j >> (LG - 1))) & (N - 1);
      localparam int UN = (j >> 1) | ((j & 1) << (LG - 1));
      if (!REV) begin : fwd
        assign av[SH]             = pv[j];
        assign at[SH*LG +: LG]    = pt[j*LG +: LG];
        assign ao[SH*LG +: LG]    = po[j*LG +: LG];
        assign ad[SH*PW +: PW]    = pd[j*PW +: PW];
        assign nv[j]              = bv[j];
        assign nt[j*LG +: LG]     = bt[j*LG +: LG];
        assign no[j*LG +: LG]     = bo[j*LG +: LG];
        assign nd[j*PW +: PW]     = bd[j*PW +: PW];
      end else begin : rev
        assign av[j]              = pv[j];
        assign at[j*LG +: LG]     = pt[j*LG +: LG];
        assign ao[j*LG +: LG]     = po[j*LG +: LG];
        assign ad[j*PW +: PW]     = pd[j*PW +: PW];
        assign nv[UN]             = bv[j];
        assign nt[UN*LG +: LG]    = bt[j*LG +: LG];
        assign no[UN*LG +: LG]    = bo[j*LG +: LG];
        assign nd[UN*PW +: PW]    = bd[j*PW +: PW];
      end
    end

    for (genvar k = 0; k < H; k++) begin : sw
      logic r0, r1;
      assign r0 = at[(2*k)*LG + BI];
      assign r1 = at[(2*k+1)*LG + BI];

      for (genvar o = 0; o < 2; o++) begin : port
        logic q0, q1, both, sel, ptr;
        logic [LG-1:0] wt, worg;

        assign q0   = av[2*k]   && (r0 == 1'(o));
        assign q1   = av[2*k+1] && (r1 == 1'(o));
        assign both = q0 & q1;
        assign sel  = both ? ptr : q1;

        assign worg = sel ? ao[(2*k+1)*LG +: LG] : ao[(2*k)*LG +: LG];

        always_comb begin
          wt     = sel ? at[(2*k+1)*LG +: LG] : at[(2*k)*LG +: LG];
          wt[BI] = sel;
        end

        assign bv[2*k+o]             = q0 | q1;
        assign bt[(2*k+o)*LG +: LG]  = wt;
        assign bo[(2*k+o)*LG +: LG]  = worg;
        assign bd[(2*k+o)*PW +: PW]  = sel ? ad[(2*k+1)*PW +: PW] : ad[(2*k)*PW +: PW];

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            ptr <= 1'b0;
          else if (both && done[worg])
            ptr <= ~sel;
        end
      end
    end
  end

  assign out_valid = st[LG-1].nv;
  assign out_tag   = st[LG-1].nt;
  assign out_pay   = st[LG-1].nd;
  assign fin_org   = st[LG-1].no;

  always_comb begin
    done = '0;
    for (int l = 0; l < N; l++)
      if (out_valid[l]) done[fin_org[l*LG +: LG]] = 1'b1;
  end

  assign in_ready = done;
endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int PORTS = 8,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [PORTS-1:0]                req_valid,
  output logic [PORTS-1:0]                req_ready,
  input  logic [PORTS*$clog2(PORTS)-1:0]  req_module,
  input  logic [PORTS*AW-1:0]             req_addr,
  input  logic [PORTS-1:0]                req_write,
  input  logic [PORTS*DW-1:0]             req_wdata,
  output logic [PORTS-1:0]                mem_valid,
  output logic [PORTS*$clog2(PORTS)-1:0]  mem_path,
  output logic [PORTS*AW-1:0]             mem_addr,
  output logic [PORTS-1:0]                mem_write,
  output logic [PORTS*DW-1:0]             mem_wdata,
  input  logic [PORTS-1:0]                rsp_valid,
  output logic [PORTS-1:0]                rsp_ready,
  input  logic [PORTS*$clog2(PORTS)-1:0]  rsp_path,
  input  logic [PORTS*DW-1:0]             rsp_data,
  output logic [PORTS-1:0]                cpu_valid,
  output logic [PORTS*$clog2(PORTS)-1:0]  cpu_module,
  output logic [PORTS*DW-1:0]             cpu_data
);
  localparam int FPW = AW + 1 + DW;

  logic [PORTS*FPW-1:0] fwd_in, fwd_out;

  for (genvar i = 0; i < PORTS; i++) begin : pack
    assign fwd_in[i*FPW +: FPW] = {req_addr[i*AW +: AW], req_write[i], req_wdata[i*DW +: DW]};
    assign {mem_addr[i*AW +: AW], mem_write[i], mem_wdata[i*DW +: DW]} = fwd_out[i*FPW +: FPW];
  end

  omega_fabric #(.N(PORTS), .PW(FPW), .REV(1'b0)) u_fwd (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_tag    (req_module),
    .in_pay    (fwd_in),
    .in_ready  (req_ready),
    .out_valid (mem_valid),
    .out_tag   (mem_path),
    .out_pay   (fwd_out)
  );

  omega_fabric #(.N(PORTS), .PW(DW), .REV(1'b1)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rsp_valid),
    .in_tag    (rsp_path),
    .in_pay    (rsp_data),
    .in_ready  (rsp_ready),
    .out_valid (cpu_valid),
    .out_tag   (cpu_module),
    .out_pay   (cpu_data)
  );
endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter int PORTS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PORTS-1:0] req_valid,
  input logic [PORTS-1:0] req_ready,
  input logic [PORTS-1:0] mem_valid,
  input logic [PORTS-1:0] rsp_valid,
  input logic [PORTS-1:0] rsp_ready,
  input logic [PORTS-1:0] cpu_valid
);
  p_req_ready_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  p_rsp_ready_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready & ~rsp_valid) == '0);

  p_req_out_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mem_valid) == $countones(req_ready));

  p_rsp_out_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cpu_valid) == $countones(rsp_ready));

  p_lone_req_passes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(req_valid) == 1) |-> (req_ready == req_valid));

  p_lone_rsp_passes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rsp_valid) == 1) |-> (rsp_ready == rsp_valid));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0 && rsp_valid == '0) |-> (mem_valid == '0 && cpu_valid == '0));
endmodule

bind omega_net omega_net_chk #(.PORTS(PORTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_valid (mem_valid),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .cpu_valid (cpu_valid)
);

// File: tb/test_omega_net.sv
`timescale 1ns/1ps
module test_omega_net;
  localparam int P  = 8;
  localparam int LG = 3;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [P-1:0]      req_valid, req_ready, req_write, mem_valid, mem_write;
  logic [P*LG-1:0]   req_module, mem_path, rsp_path, cpu_module;
  logic [P*AW-1:0]   req_addr, mem_addr;
  logic [P*DW-1:0]   req_wdata, mem_wdata, rsp_data, cpu_data;
  logic [P-1:0]      rsp_valid, rsp_ready, cpu_valid;

  omega_net #(.PORTS(P), .AW(AW), .DW(DW)) i_omega_net (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_module(req_module),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_path(mem_path), .mem_addr(mem_addr),
    .mem_write(mem_write), .mem_wdata(mem_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_path(rsp_path), .rsp_data(rsp_data),
    .cpu_valid(cpu_valid), .cpu_module(cpu_module), .cpu_data(cpu_data)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  bit              fv [P];
  logic [LG-1:0]   fdst [P];
  logic [AW-1:0]   faddr [P];
  bit              fwr [P];
  logic [DW-1:0]   fdat [P];
  bit              rv [P];
  logic [LG-1:0]   rpth [P];
  logic [DW-1:0]   rdat [P];
  logic [P-1:0]    seen_req, seen_rsp;
  int unsigned     rng = 32'h1234_5678;

  function automatic int unsigned nxt();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // links used on the way to memory: position after each switch
  function automatic logic [3*LG-1:0] fpath(input int src, input logic [LG-1:0] dst);
    logic [LG-1:0] pos;
    logic [3*LG-1:0] r;
    pos = LG'(src);
    for (int s = 0; s < LG; s++) begin
      pos = {pos[LG-2:0], pos[LG-1]};
      pos = {pos[LG-1:1], dst[LG-1-s]};
      r[s*LG +: LG] = pos;
    end
    return r;
  endfunction

  // links used on the way back: position after each switch
  function automatic logic [3*LG-1:0] bpath(input int mem, input logic [LG-1:0] tag);
    logic [LG-1:0] pos;
    logic [3*LG-1:0] r;
    pos = LG'(mem);
    for (int g = 0; g < LG; g++) begin
      pos = {pos[LG-1:1], tag[g]};
      r[g*LG +: LG] = pos;
      pos = {pos[0], pos[LG-1:1]};
    end
    return r;
  endfunction

  function automatic bit shares(input logic [3*LG-1:0] a, input logic [3*LG-1:0] b);
    for (int s = 0; s < LG; s++)
      if (a[s*LG +: LG] == b[s*LG +: LG]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic drive();
    for (int i = 0; i < P; i++) begin
      req_valid[i]            = fv[i];
      req_module[i*LG +: LG]  = fdst[i];
      req_addr[i*AW +: AW]    = faddr[i];
      req_write[i]            = fwr[i];
      req_wdata[i*DW +: DW]   = fdat[i];
      rsp_valid[i]            = rv[i];
      rsp_path[i*LG +: LG]    = rpth[i];
      rsp_data[i*DW +: DW]    = rdat[i];
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < P; i++) begin
      fv[i] = 0; fdst[i] = '0; faddr[i] = '0; fwr[i] = 0; fdat[i] = '0;
      rv[i] = 0; rpth[i] = '0; rdat[i] = '0;
    end
  endtask

  // compare the ports against the behavioural model for the current offers
  task automatic check_cycle();
    logic [3*LG-1:0] fl [P];
    logic [3*LG-1:0] bl [P];
    int nreq, nrsp;
    nreq = 0; nrsp = 0;
    for (int i = 0; i < P; i++) begin
      fl[i] = fpath(i, fdst[i]);
      bl[i] = bpath(i, rpth[i]);
    end
    for (int i = 0; i < P; i++) begin
      bit free_f, free_b;
      free_f = 1; free_b = 1;
      for (int j = 0; j < P; j++) if (j != i) begin
        if (fv[j] && shares(fl[i], fl[j])) free_f = 0;
        if (rv[j] && shares(bl[i], bl[j])) free_b = 0;
      end
      if (fv[i] && free_f) chk(req_ready[i], "R5", "clear request accepted", req_ready[i], 1);
      if (rv[i] && free_b) chk(rsp_ready[i], "R5", "clear reply accepted", rsp_ready[i], 1);
      if (!fv[i]) chk(!req_ready[i], "R6", "ready without request", req_ready[i], 0);
      if (!rv[i]) chk(!rsp_ready[i], "R6", "ready without reply", rsp_ready[i], 0);
      if (req_ready[i]) begin
        int d;
        nreq++;
        d = int'(fdst[i]);
        chk(mem_valid[d], "R1", "delivered at module port", mem_valid[d], 1);
        chk(mem_path[d*LG +: LG] == LG'(i), "R2", "path field", mem_path[d*LG +: LG], i);
        chk(mem_addr[d*AW +: AW] == faddr[i] && mem_write[d] == fwr[i] &&
            mem_wdata[d*DW +: DW] == fdat[i], "R3", "request body",
            mem_wdata[d*DW +: DW], fdat[i]);
        for (int j = i + 1; j < P; j++)
          if (req_ready[j]) chk(!shares(fl[i], fl[j]), "R6", "accepted requests share link", j, i);
      end
      if (rsp_ready[i]) begin
        int c;
        nrsp++;
        c = int'(rpth[i]);
        chk(cpu_valid[c], "R4", "reply at processor", cpu_valid[c], 1);
        chk(cpu_module[c*LG +: LG] == LG'(i), "R4", "restored module", cpu_module[c*LG +: LG], i);
        chk(cpu_data[c*DW +: DW] == rdat[i], "R4", "reply data", cpu_data[c*DW +: DW], rdat[i]);
        for (int j = i + 1; j < P; j++)
          if (rsp_ready[j]) chk(!shares(bl[i], bl[j]), "R6", "accepted replies share link", j, i);
      end
    end
    chk($countones(mem_valid) == nreq, "R6", "request outputs vs accepts", $countones(mem_valid), nreq);
    chk($countones(cpu_valid) == nrsp, "R6", "reply outputs vs accepts", $countones(cpu_valid), nrsp);
    seen_req = req_ready;
    seen_rsp = rsp_ready;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    clear_all();
    drive();
    // R9 reset state
    repeat (3) @(negedge clk);
    chk(mem_valid == '0 && cpu_valid == '0, "R9", "outputs in reset", {mem_valid, cpu_valid}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(mem_valid == '0 && cpu_valid == '0, "R9", "idle after reset", {mem_valid, cpu_valid}, 0);

    // all 64 single routes, request and reply together (R1 R2 R3 R4 R5)
    for (int s = 0; s < P; s++) begin
      for (int d = 0; d < P; d++) begin
        @(posedge clk); #1;
        clear_all();
        fv[s] = 1; fdst[s] = LG'(d); faddr[s] = AW'(s*P + d); fwr[s] = d[0];
        fdat[s] = 32'hA500_0000 + 32'(s*16 + d);
        rv[d] = 1; rpth[d] = LG'(s); rdat[d] = 32'h5A00_0000 + 32'(d*16 + s);
        drive();
        @(negedge clk);
        check_cycle();
        if (s == 3 && d == 6)
          chk(mem_path[6*LG +: LG] == 3'b011, "R2", "worked route 3 to 6", mem_path[6*LG +: LG], 3'b011);
      end
    end

    // R7: two requests to one module in one cycle
    @(posedge clk); #1;
    clear_all();
    fv[2] = 1; fdst[2] = 3'd4; fdat[2] = 32'h0000_0222;
    fv[6] = 1; fdst[6] = 3'd4; fdat[6] = 32'h0000_0666;
    drive();
    @(negedge clk);
    check_cycle();
    chk($countones({req_ready[2], req_ready[6]}) == 1, "R7", "one of two contenders",
        {req_ready[2], req_ready[6]}, 1);
    chk($countones(mem_valid) == 1, "R7", "single delivery", mem_valid, 8'h10);
    @(posedge clk); #1;
    if (seen_req[2]) fv[2] = 0;
    if (seen_req[6]) fv[6] = 0;
    drive();
    @(negedge clk);
    check_cycle();
    chk(req_ready[2] | req_ready[6], "R7", "held loser delivered", {req_ready[2], req_ready[6]}, 1);

    // R8: the same pair keeps contending for module 3
    begin
      int last;
      last = -1;
      @(posedge clk); #1;
      clear_all();
      for (int c = 0; c < 8; c++) begin
        fv[0] = 1; fdst[0] = 3'd3; fdat[0] = 32'(100 + c);
        fv[5] = 1; fdst[5] = 3'd3; fdat[5] = 32'(200 + c);
        drive();
        @(negedge clk);
        check_cycle();
        chk($countones({req_ready[0], req_ready[5]}) == 1, "R8", "exactly one winner",
            {req_ready[0], req_ready[5]}, 1);
        if (last >= 0)
          chk((req_ready[0] ? 0 : 5) != last, "R8", "winner alternates", req_ready[0] ? 0 : 5, last);
        last = req_ready[0] ? 0 : 5;
        @(posedge clk); #1;
      end
    end

    // mixed random traffic with held losers (R5 R6 R7 and routing)
    clear_all();
    drive();
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      check_cycle();
      @(posedge clk); #1;
      for (int i = 0; i < P; i++) begin
        if (seen_req[i]) fv[i] = 0;
        if (seen_rsp[i]) rv[i] = 0;
        if (c < 540) begin
          if (!fv[i] && (nxt() % 3 != 0)) begin
            fv[i] = 1; fdst[i] = LG'(nxt()); faddr[i] = AW'(nxt());
            fwr[i] = nxt() % 2; fdat[i] = nxt();
          end
          if (!rv[i] && (nxt() % 3 != 0)) begin
            rv[i] = 1; rpth[i] = LG'(nxt()); rdat[i] = nxt();
          end
        end
      end
      drive();
    end
    begin
      bit any;
      any = 0;
      for (int i = 0; i < P; i++) any |= fv[i] | rv[i];
      chk(!any, "R7", "held messages drained", any, 0);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule